// File: doc/BRIEF.md
# Audio Function Group Power State Sequencer

This block keeps the power state of an audio function group and of a set of widget nodes that live inside it. A frame-based command port carries set-state, get-state, group-reset and generic register-write commands. For every node the block holds a programmed target state and an actual state. On each frame-sync pulse, every actual state that differs from its goal moves exactly one level towards it. A move from D3 to D0 therefore takes three frames, passing through D2 and D1.

A widget is never more powered than its group. The goal of a widget is the deeper of its own target and the group state. That group state is limited to D3, because D3 already means fully off at widget level. While the group sits in D4, only group power-state commands and group resets take effect. Widget power-state commands and generic register writes are dropped. A wake request is raised only when the link is held in reset, the group is in D3 and a jack event arrives.

Each node has a two-process stepper state machine with the moves MV_HOLD, MV_DEEPER and MV_SHALLOWER. The wake gate is a two-state machine. In WK_IDLE it goes to WK_REQ when link reset, a jack event and group D3 all occur together. In WK_REQ it returns to WK_IDLE as soon as link reset drops or the group leaves D3. Power states are encoded 0 (D0, fully on) to 4 (D4, deepest) in a 4-bit field. Node number 0 is the group. Nodes 1 to NUM_WID are the widgets. Command opcodes are 0 get, 1 set power state, 2 group reset and 3 generic write.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the group's target and actual state are D2, every widget's target and actual state is D3, busy is low, and rsp_valid, wr_grant and wake_req are low.
- R2: An actual state changes only at a clock edge where frame_sync is high, and then by exactly one level towards its goal. Without frame_sync it holds, however long a target has differed.
- R3: A widget's actual state is never numerically below min(group state, 3). A widget whose target is more powered than the group settles at that limit, and it resumes towards its target as the group allows.
- R4: Power-state codes above 4 written to the group become D4, and codes above 3 written to a widget become D3.
- R5: A get command (opcode 0) to node 0..NUM_WID gives rsp_valid high one cycle later, with the target and the actual state that stood in the command cycle. A get to a higher node number gives no response, and a set to such a node changes nothing.
- R6: While the group's actual state is D4, widget set commands and generic writes (opcode 3) are ignored, and wr_grant stays low. Group set commands are still accepted. Outside D4, a generic write raises wr_grant one cycle later.
- R7: A group reset (opcode 2), accepted in any state, returns the group target to D2 and every widget target to D3. The actual states then step there one level per frame.
- R8: wake_req rises the cycle after link_rst and jack_evt are high with the group in D3. It stays high while link_rst is high and the group stays in D3, and falls the cycle after either ends. It never rises with the group in D0, D1, D2 or D4.
- R9: path_en is high only in group D0, ref_en in D0 to D1, link_en in D0 to D2, and jack_en in D0 to D3.
- R10: busy is high exactly when the group's actual state differs from its target, or when some widget's actual state differs from the deeper of its target and min(group state, 3).
- R11: A widget's actual state is never D4, even with the group in D4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One pulse per frame; advances transitions |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 get, 1 set power state, 2 group reset, 3 generic write |
| cmd_node | input | NODE_W (3) | 0 group, 1..NUM_WID widgets |
| cmd_data | input | 4 | Power-state code for set commands |
| rsp_valid | output | 1 | Get response valid |
| rsp_tgt | output | 4 | Target state of the addressed node |
| rsp_act | output | 4 | Actual state of the addressed node |
| wr_grant | output | 1 | Generic write accepted |
| link_rst | input | 1 | Link is held in reset |
| jack_evt | input | 1 | Jack detection event |
| wake_req | output | 1 | Wake request to the link |
| grp_state | output | 4 | Group actual state |
| wid_state | output | NUM_WID*4 (16) | Widget actual states, widget 1 in the low nibble |
| busy | output | 1 | A transition is still pending |
| path_en | output | 1 | Converters and audio path powered |
| ref_en | output | 1 | Analogue references powered |
| link_en | output | 1 | Link and register access active |
| jack_en | output | 1 | Jack detection active |

## Verification
rsp_valid, rsp_tgt, rsp_act and wr_grant are registered and appear at the first clock edge after the command cycle. A state step lands on the edge where frame_sync is high. wake_req follows its conditions by one edge. busy and the four enables follow the actual states with no further delay. The bench drives every input on a falling edge and reads the results on the next falling edge, so each result is read exactly one edge after its cause. The bench sweeps every group target against rotating widget target patterns and checks every node after every frame. It also idles for long stretches to confirm that nothing moves without a frame pulse.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int PS_W = 4;

    typedef enum logic [2:0] {
        PS_D0 = 3'd0,
        PS_D1 = 3'd1,
        PS_D2 = 3'd2,
        PS_D3 = 3'd3,
        PS_D4 = 3'd4
    } pstate_t;

    typedef enum logic [1:0] {
        OP_GET   = 2'd0,
        OP_SETPS = 2'd1,
        OP_RESET = 2'd2,
        OP_WRITE = 2'd3
    } cmd_op_t;

    // Undefined codes fall to the deepest legal state of the node kind
    function automatic pstate_t ps_clamp(input logic [3:0] code, input pstate_t deepest);
        if (code > {1'b0, deepest}) return deepest;
        return pstate_t'(code[2:0]);
    endfunction

    function automatic pstate_t ps_deeper_of(input pstate_t a, input pstate_t b);
        return (a > b) ? a : b;
    endfunction

    // Widgets stop at D3; group D4 maps to widget D3
    function automatic pstate_t ps_widget_cap(input pstate_t g);
        return (g == PS_D4) ? PS_D3 : g;
    endfunction

endpackage

// File: rtl/pwr_node_stepper.sv
module pwr_node_stepper
    import pwr_seq_pkg::*;
#(
    parameter pstate_t RST_STATE = PS_D3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step,
    input  pstate_t tgt,
    input  pstate_t cap,
    output pstate_t act,
    output pstate_t nxt
);

    typedef enum logic [1:0] {
        MV_HOLD      = 2'd0,
        MV_DEEPER    = 2'd1,
        MV_SHALLOWER = 2'd2
    } move_t;

    pstate_t goal;
    pstate_t stepped;
    move_t   mv;

    always_comb begin
        goal = ps_deeper_of(tgt, cap);
        if (act < goal)      mv = MV_DEEPER;
        else if (act > goal) mv = MV_SHALLOWER;
        else                 mv = MV_HOLD;
        unique case (mv)
            MV_DEEPER:    stepped = pstate_t'(act + 3'd1);
            MV_SHALLOWER: stepped = pstate_t'(act - 3'd1);
            default:      stepped = act;
        endcase
        nxt = step ? stepped : act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act <= RST_STATE;
        else        act <= nxt;
    end

    // R2: no movement without a frame pulse
    a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) |-> $stable(act));

    // R2: each move is a single adjacent level
    a_r2_adjacent_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act != $past(act)) |-> (((act - $past(act)) == 3'd1) || (($past(act) - act) == 3'd1)));

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        act <= PS_D4);

endmodule

// File: rtl/pwr_wake_gate.sv
module pwr_wake_gate
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    link_rst,
    input  logic    jack_evt,
    input  pstate_t grp_act,
    output logic    wake_req
);

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_REQ  = 1'b1
    } wake_st_t;

    wake_st_t st, st_nxt;
    logic     may_wake;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= WK_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        may_wake = link_rst && (grp_act == PS_D3);
        unique case (st)
            WK_IDLE: st_nxt = (may_wake && jack_evt) ? WK_REQ : WK_IDLE;
            WK_REQ:  st_nxt = may_wake ? WK_REQ : WK_IDLE;
            default: st_nxt = WK_IDLE;
        endcase
    end

    assign wake_req = (st == WK_REQ);

    // R8: a wake is only ever raised from D3 with the link in reset
    a_r8_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(link_rst) && ($past(grp_act) == PS_D3)));

    a_r8_wake_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(jack_evt));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int NUM_WID = 4,
    localparam int NODE_W = $clog2(NUM_WID + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_sync,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [NODE_W-1:0]       cmd_node,
    input  logic [3:0]              cmd_data,
    output logic                    rsp_valid,
    output logic [3:0]              rsp_tgt,
    output logic [3:0]              rsp_act,
    output logic                    wr_grant,
    input  logic                    link_rst,
    input  logic                    jack_evt,
    output logic                    wake_req,
    output logic [3:0]              grp_state,
    output logic [NUM_WID*PS_W-1:0] wid_state,
    output logic                    busy,
    output logic                    path_en,
    output logic                    ref_en,
    output logic                    link_en,
    output logic                    jack_en
);

    cmd_op_t op;
    pstate_t grp_tgt, grp_act, grp_nxt, wid_cap, cur_cap;
    pstate_t wid_tgt [NUM_WID];
    pstate_t wid_act [NUM_WID];
    pstate_t wid_nxt [NUM_WID];
    logic    [NUM_WID-1:0] wid_hit;
    logic    grp_hit, node_ok, in_d4;
    pstate_t sel_tgt, sel_act, rsp_tgt_q, rsp_act_q;

    assign op      = cmd_op_t'(cmd_op);
    assign grp_hit = (cmd_node == '0);
    assign in_d4   = (grp_act == PS_D4);
    assign wid_cap = ps_widget_cap(grp_nxt);
    assign cur_cap = ps_widget_cap(grp_act);

    // Node decode and read mux
    always_comb begin
        sel_tgt = grp_tgt;
        sel_act = grp_act;
        for (int i = 0; i < NUM_WID; i++) begin
            wid_hit[i] = (cmd_node == NODE_W'(i + 1));
            if (wid_hit[i]) begin
                sel_tgt = wid_tgt[i];
                sel_act = wid_act[i];
            end
        end
        node_ok = grp_hit || (|wid_hit);
    end

    // Target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_tgt <= PS_D2;
            for (int i = 0; i < NUM_WID; i++) wid_tgt[i] <= PS_D3;
        end else if (cmd_valid) begin
            unique case (op)
                OP_SETPS: begin
                    if (grp_hit) grp_tgt <= ps_clamp(cmd_data, PS_D4);
                    for (int i = 0; i < NUM_WID; i++)
                        if (wid_hit[i] && !in_d4) wid_tgt[i] <= ps_clamp(cmd_data, PS_D3);
                end
                OP_RESET: begin
                    grp_tgt <= PS_D2;
                    for (int i = 0; i < NUM_WID; i++) wid_tgt[i] <= PS_D3;
                end
                default: ;
            endcase
        end
    end

    // Response and write grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tgt_q <= PS_D0;
            rsp_act_q <= PS_D0;
            wr_grant  <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid && (op == OP_GET) && node_ok;
            rsp_tgt_q <= sel_tgt;
            rsp_act_q <= sel_act;
            wr_grant  <= cmd_valid && (op == OP_WRITE) && !in_d4;
        end
    end

    assign rsp_tgt = {1'b0, rsp_tgt_q};
    assign rsp_act = {1'b0, rsp_act_q};

    pwr_node_stepper #(.RST_STATE(PS_D2)) u_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (frame_sync),
        .tgt   (grp_tgt),
        .cap   (PS_D0),
        .act   (grp_act),
        .nxt   (grp_nxt)
    );

    for (genvar i = 0; i < NUM_WID; i++) begin : g_wid
        pwr_node_stepper #(.RST_STATE(PS_D3)) u_step (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (frame_sync),
            .tgt   (wid_tgt[i]),
            .cap   (wid_cap),
            .act   (wid_act[i]),
            .nxt   (wid_nxt[i])
        );
        assign wid_state[i*PS_W +: PS_W] = {1'b0, wid_act[i]};

        // R3: widget never more powered than the group allows
        a_r3_widget_capped: assert property (@(posedge clk) disable iff (!rst_n)
            wid_act[i] >= ps_widget_cap(grp_act));

        // R11: widgets have no D4
        a_r11_widget_range: assert property (@(posedge clk) disable iff (!rst_n)
            wid_act[i] != PS_D4);

        // R6: widget targets frozen while the group is in D4, except by group reset
        a_r6_d4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (in_d4 && !(cmd_valid && op == OP_RESET)) |=> $stable(wid_tgt[i]));
    end

    pwr_wake_gate u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_rst (link_rst),
        .jack_evt (jack_evt),
        .grp_act  (grp_act),
        .wake_req (wake_req)
    );

    always_comb begin
        busy = (grp_act != grp_tgt);
        for (int i = 0; i < NUM_WID; i++)
            if (wid_act[i] != ps_deeper_of(wid_tgt[i], cur_cap)) busy = 1'b1;
    end

    assign grp_state = {1'b0, grp_act};
    assign path_en   = (grp_act == PS_D0);
    assign ref_en    = (grp_act <= PS_D1);
    assign link_en   = (grp_act <= PS_D2);
    assign jack_en   = (grp_act <= PS_D3);

    // R5: responses only follow a get command
    a_r5_rsp_after_get: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cmd_valid) && ($past(cmd_op) == OP_GET)));

    // R6: no generic write granted while in D4
    a_r6_no_grant_in_d4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp_act) == PS_D4) |-> !wr_grant);

    // R9: enable ladder is nested
    a_r9_enable_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (path_en |-> ref_en) and (ref_en |-> link_en) and (link_en |-> jack_en));

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
    localparam int NW  = 4;
    localparam int NDW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, frame_sync, cmd_valid, link_rst, jack_evt;
    logic [1:0] cmd_op;
    logic [NDW-1:0] cmd_node;
    logic [3:0] cmd_data;
    logic rsp_valid, wr_grant, wake_req, busy, path_en, ref_en, link_en, jack_en;
    logic [3:0] rsp_tgt, rsp_act, grp_state;
    logic [NW*4-1:0] wid_state;

    pwr_seq_top #(.NUM_WID(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_tgt(rsp_tgt), .rsp_act(rsp_act), .wr_grant(wr_grant),
        .link_rst(link_rst), .jack_evt(jack_evt), .wake_req(wake_req),
        .grp_state(grp_state), .wid_state(wid_state), .busy(busy),
        .path_en(path_en), .ref_en(ref_en), .link_en(link_en), .jack_en(jack_en)
    );

    int total = 0;
    int bad   = 0;
    int mtgt [0:NW];
    int mact [0:NW];

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int mstep(input int a, input int g);
        if (a < g) return a + 1;
        if (a > g) return a - 1;
        return a;
    endfunction

    function automatic int mbusy();
        int c = (mact[0] > 3) ? 3 : mact[0];
        int b = (mact[0] != mtgt[0]) ? 1 : 0;
        for (int w = 1; w <= NW; w++)
            if (mact[w] != imax(mtgt[w], c)) b = 1;
        return b;
    endfunction

    task automatic check_all(input string tag2);
        check(tag2, "group state", int'(grp_state), mact[0]);
        for (int w = 1; w <= NW; w++) begin
            check("R3", $sformatf("widget %0d state", w), int'(wid_state[(w-1)*4 +: 4]), mact[w]);
            check("R11", "widget not D4", int'(wid_state[(w-1)*4 +: 4] == 4'd4), 0);
        end
        check("R10", "busy", int'(busy), mbusy());
        check("R9", "path_en", int'(path_en), int'(mact[0] == 0));
        check("R9", "ref_en",  int'(ref_en),  int'(mact[0] <= 1));
        check("R9", "link_en", int'(link_en), int'(mact[0] <= 2));
        check("R9", "jack_en", int'(jack_en), int'(mact[0] <= 3));
    endtask

    task automatic model_reset_targets();
        mtgt[0] = 2;
        for (int w = 1; w <= NW; w++) mtgt[w] = 3;
    endtask

    task automatic cmd(input int op, input int node, input int data);
        bit in_d4 = (mact[0] == 4);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_node = node[NDW-1:0]; cmd_data = data[3:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R5", "rsp_valid", int'(rsp_valid), int'(op == 0 && node <= NW));
        if (op == 0 && node <= NW) begin
            check("R5", $sformatf("target node %0d", node), int'(rsp_tgt), mtgt[node]);
            check("R5", $sformatf("actual node %0d", node), int'(rsp_act), mact[node]);
        end
        if (op == 3) check("R6", "wr_grant", int'(wr_grant), int'(!in_d4));
        if (op == 1 && node == 0) mtgt[0] = (data > 4) ? 4 : data;
        if (op == 1 && node >= 1 && node <= NW && !in_d4) mtgt[node] = (data > 3) ? 3 : data;
        if (op == 2) model_reset_targets();
    endtask

    task automatic frame(input string tag2);
        int c;
        @(negedge clk); frame_sync = 1'b1;
        @(negedge clk); frame_sync = 1'b0;
        mact[0] = mstep(mact[0], mtgt[0]);
        c = (mact[0] > 3) ? 3 : mact[0];
        for (int w = 1; w <= NW; w++) mact[w] = mstep(mact[w], imax(mtgt[w], c));
        check_all(tag2);
    endtask

    task automatic get_all();
        for (int n = 0; n <= NW; n++) cmd(0, n, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_sync = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        cmd_node = '0; cmd_data = '0; link_rst = 1'b0; jack_evt = 1'b0;
        model_reset_targets();
        mact[0] = 2;
        for (int w = 1; w <= NW; w++) mact[w] = 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        check("R1", "rsp_valid", int'(rsp_valid), 0);
        check("R1", "wr_grant", int'(wr_grant), 0);
        check("R1", "wake_req", int'(wake_req), 0);
        get_all();

        // R2: full D3->D0 walk on a widget via group D0
        cmd(1, 0, 0);
        cmd(1, 1, 0);
        repeat (20) @(negedge clk);
        check_all("R2");  // nothing moved without frame_sync
        for (int f = 0; f < 4; f++) frame("R2");
        get_all();

        // Sweep all group targets against rotating widget patterns
        for (int gt = 0; gt <= 4; gt++) begin
            for (int p = 0; p < 4; p++) begin
                cmd(1, 0, gt);
                for (int w = 1; w <= NW; w++) cmd(1, w, (w + p) % 4);
                check("R10", "busy after set", int'(busy), mbusy());
                for (int f = 0; f < 5; f++) frame("R2");
                get_all();
            end
        end

        // R4 clamping
        cmd(1, 0, 0);
        for (int f = 0; f < 5; f++) frame("R2");
        cmd(1, 0, 9);   cmd(0, 0, 0);
        check("R4", "group clamp 9", int'(rsp_tgt), 4);
        cmd(1, 2, 7);   cmd(0, 2, 0);
        check("R4", "widget clamp 7", int'(rsp_tgt), 3);
        cmd(1, 3, 15);  cmd(0, 3, 0);
        check("R4", "widget clamp 15", int'(rsp_tgt), 3);
        cmd(1, 0, 15);  cmd(0, 0, 0);
        check("R4", "group clamp 15", int'(rsp_tgt), 4);

        // R5 unknown nodes
        cmd(0, 5, 0);
        cmd(1, 6, 0);
        cmd(0, 7, 0);
        get_all();

        // R6 gating in D4 (group target 4 already set)
        cmd(3, 0, 0);   // not yet in D4: grant expected
        for (int f = 0; f < 5; f++) frame("R6");
        check("R6", "group at D4", int'(grp_state), 4);
        cmd(3, 0, 0);
        cmd(1, 1, 0);
        cmd(0, 1, 0);
        get_all();
        // R7 group reset accepted while in D4
        cmd(1, 2, 1);
        cmd(2, 0, 0);
        get_all();
        check("R7", "group target after reset", mtgt[0], 2);
        for (int f = 0; f < 3; f++) frame("R7");
        cmd(1, 0, 0);   // R6 group set accepted
        cmd(0, 0, 0);
        for (int f = 0; f < 3; f++) frame("R6");
        cmd(3, 0, 0);

        // R8 wake
        cmd(1, 0, 3);
        for (int f = 0; f < 4; f++) frame("R8");
        @(negedge clk); link_rst = 1'b1; jack_evt = 1'b1;
        @(negedge clk); jack_evt = 1'b0;
        check("R8", "wake in D3", int'(wake_req), 1);
        repeat (3) @(negedge clk);
        check("R8", "wake held", int'(wake_req), 1);
        link_rst = 1'b0;
        @(negedge clk);
        check("R8", "wake drop on link", int'(wake_req), 0);
        link_rst = 1'b1; jack_evt = 1'b1;
        @(negedge clk);
        check("R8", "wake again", int'(wake_req), 1);
        jack_evt = 1'b0;
        cmd(1, 0, 2);
        frame("R8");
        @(negedge clk);
        check("R8", "wake drop leaving D3", int'(wake_req), 0);
        jack_evt = 1'b1;
        repeat (4) @(negedge clk);
        check("R8", "no wake in D2", int'(wake_req), 0);
        jack_evt = 1'b0;
        cmd(1, 0, 4);
        for (int f = 0; f < 3; f++) frame("R8");
        jack_evt = 1'b1;
        repeat (4) @(negedge clk);
        check("R8", "no wake in D4", int'(wake_req), 0);
        jack_evt = 1'b0;
        link_rst = 1'b0;
        cmd(1, 0, 0);
        for (int f = 0; f < 5; f++) frame("R2");
        jack_evt = 1'b1; link_rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "no wake in D0", int'(wake_req), 0);
        jack_evt = 1'b0; link_rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule